// File: doc/BRIEF.md
# CAN Transmit Dominant Timeout Guard

This block sits between the transmit output of a CAN protocol controller and the digital inputs of a bus transceiver. It watches the controller's transmit level and passes it to the driver. If the level stays dominant (low) longer than a programmable number of clock cycles, it forces the driver recessive and disables it. A node whose controller or firmware has locked up with its transmit line low therefore cannot hold the bus dominant and block every other node.

The timer starts only on a high-to-low transition of the synchronized transmit level. A level that is already low when reset is released never reaches the driver. The fault ends as soon as the transmit level is seen recessive again. The receive path is a straight wire from the bus receive level to the controller, so the node keeps hearing traffic while its driver is locked out. The protocol can legally send eleven dominant bits in a row, so the timeout must span at least eleven bit times. The slowest bit rate the node can then send at is eleven divided by the timeout.

Top module: `can_dom_guard`

## Requirements
- R1: While reset is held and right after its release, `fault` is 0, `drv_en` is 1 (1 = driver enabled) and `drv_txd` is 1 (1 = recessive, 0 = dominant).
- R2: `txd_in` passes through a two-flop synchronizer. A change of the synchronized level from 1 to 0 arms the timer, and `drv_txd` goes to 0 after the third rising clock edge that follows the change of `txd_in`.
- R3: If `txd_in` stays 0 for more than `TIMEOUT_CYC` clock cycles, `fault` rises after rising edge number `TIMEOUT_CYC`+3 from the falling change, after exactly `TIMEOUT_CYC` cycles of dominant drive.
- R4: While `fault` is 1, `drv_txd` is 1 and `drv_en` is 0. Whenever `fault` is 0, `drv_en` is 1.
- R5: A fault clears after the third rising edge that follows the return of `txd_in` to 1, and `drv_en` returns to 1 at the same time.
- R6: `rxd_out` equals `bus_rx` at all times, including during a fault.
- R7: The timeout counter saturates rather than wrapping: a dominant level held for many times `TIMEOUT_CYC` keeps `fault` at 1 without a gap until `txd_in` returns to 1.
- R8: A dominant pulse of `TIMEOUT_CYC` cycles or less is passed to `drv_txd` with the same length and raises no fault. The next falling change restarts the count from zero.
- R9: A `txd_in` already at 0 when reset is released neither drives `drv_txd` to 0 nor raises `fault`, however long it lasts. A later 1-to-0 change arms the timer as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_in | input | 1 | Raw transmit level from the controller (0 = dominant) |
| bus_rx | input | 1 | Receive level from the transceiver |
| drv_txd | output | 1 | Transmit level to the driver (1 = recessive) |
| drv_en | output | 1 | Driver enable, 0 while timed out |
| rxd_out | output | 1 | Receive level to the controller |
| fault | output | 1 | High while the timeout holds the driver off |

## Verification
The hardest situations to reach are the exact expiry boundary and a dominant level present before reset is released. The bench runs dominant pulses of exactly `TIMEOUT_CYC` and `TIMEOUT_CYC`+1 cycles and checks every cycle. The first must give no fault, and the second must give a fault of one cycle. To reach the second situation, the bench holds `txd_in` low through reset, waits several timeouts, and then makes a fresh falling change to show that the timer still arms.

// File: rtl/can_dom_guard.sv
module can_dom_guard #(
  parameter int unsigned TIMEOUT_CYC = 1000,
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic bus_rx,
  output logic drv_txd,
  output logic drv_en,
  output logic rxd_out,
  output logic fault
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             sync_a, sync_b, prev_b;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             fall;

  assign fall = prev_b & ~sync_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      prev_b <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
      fault  <= 1'b0;
    end else begin
      sync_a <= txd_in;
      sync_b <= sync_a;
      prev_b <= sync_b;
      if (sync_b) begin
        armed <= 1'b0;
        cnt   <= '0;
        fault <= 1'b0;
      end else if (fall) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == CNT_LAST) fault <= 1'b1;
      end
    end
  end

  assign drv_txd = ~(armed & ~fault);
  assign drv_en  = ~fault;
  assign rxd_out = bus_rx;

  a_r2_arm_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(prev_b) && !$past(sync_b)));

  a_r3_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(cnt) == CNT_LAST);

  a_r5_clear_on_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && sync_b) |=> !fault);

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt == CNT_MAX && !sync_b) |=> (cnt == CNT_MAX && fault));

  a_r9_fault_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(armed));

  a_r4_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (drv_txd && !drv_en));

endmodule

// File: tb/can_dom_guard_test.sv
module can_dom_guard_test;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_in = 1'b1;
  logic bus_rx = 1'b1;
  logic drv_txd, drv_en, rxd_out, fault;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_dom_guard #(.TIMEOUT_CYC(T)) uut (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .bus_rx(bus_rx),
    .drv_txd(drv_txd), .drv_en(drv_en), .rxd_out(rxd_out), .fault(fault)
  );

  localparam int NV = 7;
  localparam int LENS [NV] = '{1, 3, T-1, T, T+1, T+5, 3*T};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int len);
    @(negedge clk);
    txd_in = 1'b0;
    for (int k = 1; k <= len + 4; k++) begin
      @(negedge clk);
      bus_rx = k[0];
      #0.5;
      begin
        logic exp_f, exp_d;
        int hi;
        hi = (len + 2 < T + 2) ? len + 2 : T + 2;
        exp_f = (k >= T + 3) && (k <= len + 2);
        exp_d = !((k >= 3) && (k <= hi));
        chk(exp_f ? "R3/R7 fault high" : "R5/R8 fault low", fault, exp_f);
        chk(exp_f ? "R4 forced recessive" : "R2/R8 driver level", drv_txd, exp_d);
        chk("R4 enable", drv_en, ~exp_f);
        chk("R6 rx passthrough", rxd_out, bus_rx);
      end
      if (k == len) txd_in = 1'b1;
    end
  endtask

  initial begin
    idle(2);
    #0.5;
    chk("R1 reset fault", fault, 1'b0);
    chk("R1 reset enable", drv_en, 1'b1);
    chk("R1 reset driver", drv_txd, 1'b1);
    rst_n = 1'b1;
    idle(1);
    #0.5;
    chk("R1 after release driver", drv_txd, 1'b1);
    chk("R1 after release fault", fault, 1'b0);
    idle(5);

    for (int v = 0; v < NV; v++) begin
      pulse(LENS[v]);
      idle(4);
    end

    rst_n = 1'b0;
    txd_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge clk);
      #0.5;
      chk("R9 no drive from held low", drv_txd, 1'b1);
      chk("R9 no fault from held low", fault, 1'b0);
    end
    txd_in = 1'b1;
    idle(5);
    pulse(T + 2);
    idle(4);

    bus_rx = 1'b0;
    #0.5;
    chk("R6 rx low", rxd_out, 1'b0);
    bus_rx = 1'b1;
    #0.5;
    chk("R6 rx high", rxd_out, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule